// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits behind a UART deserializer on a shared multidrop line. Each completed frame is presented for one cycle on a strobe, along with its data byte and the extra bit that follows it. In nine-bit operation the extra bit is the ninth data bit, and a one there marks the frame as an address. In eight-bit operation the extra bit is the stop bit. When recognition is enabled, the filter compares each address frame against two patterns built from a node address register and a mask register:

- **Own address.** A zero bit in the mask makes the matching address bit a don't-care.
- **Broadcast address.** This is the OR of address and mask. Its zero bits are don't-cares.

The receive interrupt pulse is raised only for address frames that hit either pattern, and for data frames that arrive while the node is selected. Every address frame re-decides the selection.

With recognition disabled the filter is transparent: every frame raises the interrupt pulse and the match indication is held high. At reset the registers are expected to hold zero. All address bits are then don't-cares, so any address selects the node.

Top module: `uaf_addr_filter`

## Requirements
- R1: With `mp_en` low, every strobed frame produces `rx_irq` high in the following cycle, whatever its byte and extra bit.
- R2: With `mp_en` low, `match_out` is high.
- R3: With `mp_en` high and `nine_mode` high, an address frame (`rx_bit9`=1) whose byte equals `node_addr` on every bit where `node_mask` is 1 raises `rx_irq` and sets `match_out`. With `node_mask`=8'hFF this requires an exact match; for example, address 8'hF2 with mask 8'hFE accepts 8'hF3 and rejects 8'hF0.
- R4: An address frame whose byte has a 1 in every bit position where (`node_addr` | `node_mask`) is 1 is accepted as broadcast. For example, 8'hFF with address 8'hA5 and mask 8'hFF.
- R5: An address frame that hits neither pattern gives no `rx_irq` and drives `match_out` low.
- R6: A data frame (`rx_bit9`=0 in nine-bit mode) raises `rx_irq` only while the node is selected by the last address frame.
- R7: With `nine_mode` low, `rx_bit9` is the stop bit. A frame with stop=1 is treated as an address frame. A frame with stop=0 never raises `rx_irq` and leaves `match_out` unchanged.
- R8: After reset, `rx_irq` is low and `match_out` is low with `mp_en` high. With `node_addr`=`node_mask`=0, any address frame is accepted.
- R9: `rx_irq` is a single-cycle pulse. It is high only in the cycle after a strobe.
- R10: A new address frame re-arms the filter. A miss after a hit deselects the node, so later data frames are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe for a completed frame |
| rx_byte | input | DW | Received data byte |
| rx_bit9 | input | 1 | Ninth bit (nine-bit mode) or stop bit (eight-bit mode) |
| nine_mode | input | 1 | 1 = nine-bit frames, 0 = eight-bit frames |
| mp_en | input | 1 | Multiprocessor recognition enable |
| node_addr | input | DW | Node address register |
| node_mask | input | DW | Mask register, 0 bits are don't-care |
| rx_irq | output | 1 | Receive interrupt pulse |
| match_out | output | 1 | Node selected (high when recognition is off) |

## Verification
The hardest case to reach is a frame that leaves the selection state untouched: an eight-bit frame with a bad stop bit arriving while the node is selected, or a data frame arriving while it is not. The bench first selects or deselects the node with a chosen address frame. It then sends the frame under test, so that a stale or wrongly updated selection shows on `match_out` and on whether the following data frame raises the interrupt. The worked mask case and the broadcast case are driven with register values that make the own-address and broadcast patterns disagree.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    typedef enum logic [1:0] {
        FK_OPEN = 2'd0,
        FK_ADDR = 2'd1,
        FK_DATA = 2'd2,
        FK_BAD  = 2'd3
    } frame_kind_e;

    typedef struct packed {
        logic irq;
        logic sel_load;
        logic sel_val;
    } verdict_t;

    function automatic frame_kind_e classify(input logic mp_en,
                                             input logic nine_mode,
                                             input logic extra_bit);
        frame_kind_e k;
        if (!mp_en)
            k = FK_OPEN;
        else if (nine_mode)
            k = extra_bit ? FK_ADDR : FK_DATA;
        else
            k = extra_bit ? FK_ADDR : FK_BAD;
        return k;
    endfunction

    function automatic verdict_t decide(input frame_kind_e kind,
                                        input logic hit,
                                        input logic sel_now);
        verdict_t v;
        v = '0;
        unique case (kind)
            FK_OPEN: v.irq = 1'b1;
            FK_ADDR: begin
                v.irq      = hit;
                v.sel_load = 1'b1;
                v.sel_val  = hit;
            end
            FK_DATA: v.irq = sel_now;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/uaf_addr_match.sv
module uaf_addr_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rx,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] mask,
    output logic          given_hit,
    output logic          bcast_hit
);
    logic [DW-1:0] bcast_pat;
    logic [DW-1:0] given_ok;
    logic [DW-1:0] bcast_ok;

    assign bcast_pat = addr | mask;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign given_ok[i] = ~mask[i] | ~(rx[i] ^ addr[i]);
        assign bcast_ok[i] = ~bcast_pat[i] | rx[i];
    end

    assign given_hit = &given_ok;
    assign bcast_hit = &bcast_ok;
endmodule

// File: rtl/uaf_select_reg.sv
module uaf_select_reg
    import uaf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frm_valid,
    input  verdict_t verdict,
    output logic     sel_q,
    output logic     irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= frm_valid & verdict.irq;
            if (frm_valid && verdict.sel_load)
                sel_q <= verdict.sel_val;
        end
    end

    p_pulse_only_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !irq_q)
        else $error("R9 irq without strobe");

    p_sel_held_r7: assert property (@(posedge clk) disable iff (rst)
        !(frm_valid && verdict.sel_load) |=> $stable(sel_q))
        else $error("R7 selection changed without address frame");
endmodule

// File: rtl/uaf_addr_filter.sv
module uaf_addr_filter
    import uaf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frm_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_bit9,
    input  logic          nine_mode,
    input  logic          mp_en,
    input  logic [DW-1:0] node_addr,
    input  logic [DW-1:0] node_mask,
    output logic          rx_irq,
    output logic          match_out
);
    logic        given_hit;
    logic        bcast_hit;
    logic        sel_q;
    frame_kind_e kind;
    verdict_t    verdict;

    uaf_addr_match #(.DW(DW)) u_match (
        .rx        (rx_byte),
        .addr      (node_addr),
        .mask      (node_mask),
        .given_hit (given_hit),
        .bcast_hit (bcast_hit)
    );

    always_comb begin
        kind    = classify(mp_en, nine_mode, rx_bit9);
        verdict = decide(kind, given_hit | bcast_hit, sel_q);
    end

    uaf_select_reg u_sel (
        .clk       (clk),
        .rst       (rst),
        .frm_valid (frm_valid),
        .verdict   (verdict),
        .sel_q     (sel_q),
        .irq_q     (rx_irq)
    );

    assign match_out = ~mp_en | sel_q;

    p_open_irq_r1: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !mp_en |=> rx_irq)
        else $error("R1 open frame lost");

    p_open_match_r2: assert property (@(posedge clk) disable iff (rst)
        !mp_en |-> match_out)
        else $error("R2 match low while disabled");

    p_exact_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (&node_mask) |-> (given_hit == (rx_byte == node_addr)))
        else $error("R3 full mask not exact");

    p_bcast_r4: assert property (@(posedge clk) disable iff (rst)
        ((rx_byte & (node_addr | node_mask)) == (node_addr | node_mask)) |-> bcast_hit)
        else $error("R4 broadcast missed");

    p_miss_r5: assert property (@(posedge clk) disable iff (rst)
        frm_valid && mp_en && rx_bit9 && !given_hit && !bcast_hit |=> !rx_irq && !sel_q)
        else $error("R5 miss accepted");

    p_data_gate_r6: assert property (@(posedge clk) disable iff (rst)
        frm_valid && mp_en && nine_mode && !rx_bit9 |=> rx_irq == $past(sel_q))
        else $error("R6 data gating wrong");

    p_bad_stop_r7: assert property (@(posedge clk) disable iff (rst)
        frm_valid && mp_en && !nine_mode && !rx_bit9 |=> !rx_irq)
        else $error("R7 bad stop accepted");

    p_zero_regs_r8: assert property (@(posedge clk) disable iff (rst)
        (node_addr == '0) && (node_mask == '0) |-> given_hit)
        else $error("R8 zero regs reject");

    p_rearm_r10: assert property (@(posedge clk) disable iff (rst)
        frm_valid && mp_en && rx_bit9 |=> sel_q == $past(given_hit | bcast_hit))
        else $error("R10 address frame did not re-decide");
endmodule

// File: tb/sim_uaf_addr_filter.sv
module sim_uaf_addr_filter;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    typedef struct {
        logic  irq;
        logic  match;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frm_valid = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic          rx_bit9 = 1'b0;
    logic          nine_mode = 1'b1;
    logic          mp_en = 1'b1;
    logic [DW-1:0] node_addr = '0;
    logic [DW-1:0] node_mask = '0;
    logic          rx_irq;
    logic          match_out;

    int   checks = 0;
    int   errors = 0;
    bit   running = 0;
    bit   done = 0;
    logic m_sel = 1'b0;
    exp_t q[$];

    uaf_addr_filter #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .rx_byte(rx_byte),
        .rx_bit9(rx_bit9), .nine_mode(nine_mode), .mp_en(mp_en),
        .node_addr(node_addr), .node_mask(node_mask),
        .rx_irq(rx_irq), .match_out(match_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [DW-1:0] b,
                                       input logic [DW-1:0] a,
                                       input logic [DW-1:0] m);
        logic own = 1'b1;
        logic bc  = 1'b1;
        for (int i = 0; i < DW; i++) begin
            if (m[i] && (b[i] != a[i])) own = 1'b0;
            if ((a[i] || m[i]) && !b[i]) bc = 1'b0;
        end
        return own || bc;
    endfunction

    task automatic setup(input logic en, input logic nine,
                         input logic [DW-1:0] a, input logic [DW-1:0] m);
        @(negedge clk);
        mp_en = en; nine_mode = nine; node_addr = a; node_mask = m;
    endtask

    task automatic send(input logic [DW-1:0] b, input logic extra, input string tag);
        exp_t e;
        @(negedge clk);
        rx_byte = b; rx_bit9 = extra; frm_valid = 1'b1;
        if (!mp_en) begin
            e.irq = 1'b1;
        end else if (extra) begin
            m_sel = model_hit(b, node_addr, node_mask);
            e.irq = m_sel;
        end else if (nine_mode) begin
            e.irq = m_sel;
        end else begin
            e.irq = 1'b0;
        end
        e.match = !mp_en || m_sel;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (running) begin
                automatic logic fired = frm_valid;
                #2;
                if (fired && q.size() > 0) begin
                    automatic exp_t e = q.pop_front();
                    check({e.tag, " irq"}, rx_irq, e.irq);
                    check({e.tag, " match"}, match_out, e.match);
                end else begin
                    check("R9 idle irq", rx_irq, 1'b0);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset irq", rx_irq, 1'b0);
        check("R8 reset match", match_out, 1'b0);
        running = 1;

        // R8: zero registers accept anything; R6 data passes when selected
        send(8'h5A, 1'b1, "R8 zero regs addr");
        send(8'h33, 1'b0, "R6 data selected");

        // R3 exact match, R5/R10 miss, R6 drop, R4 broadcast
        setup(1'b1, 1'b1, 8'hA5, 8'hFF);
        send(8'hA5, 1'b1, "R3 exact hit");
        send(8'h01, 1'b0, "R6 data after hit");
        send(8'hA4, 1'b1, "R5 R10 miss rearm");
        send(8'h02, 1'b0, "R6 data dropped");
        send(8'h03, 1'b0, "R6 data dropped again");
        send(8'hFF, 1'b1, "R4 broadcast");
        send(8'h04, 1'b0, "R6 data after broadcast");

        // R3 masked case
        setup(1'b1, 1'b1, 8'hF2, 8'hFE);
        send(8'hF3, 1'b1, "R3 masked hit");
        send(8'hF0, 1'b1, "R3 masked miss");
        send(8'hF2, 1'b1, "R3 masked hit low bit0");

        // R7 eight-bit mode
        setup(1'b1, 1'b0, 8'h3C, 8'hFF);
        send(8'h3C, 1'b1, "R7 stop ok hit");
        send(8'h3C, 1'b0, "R7 bad stop while selected");
        send(8'h11, 1'b1, "R7 stop ok miss");
        send(8'h3C, 1'b0, "R7 bad stop while deselected");

        // R1 R2 recognition disabled
        setup(1'b0, 1'b1, 8'h3C, 8'hFF);
        send(8'h99, 1'b0, "R1 R2 open data");
        send(8'h77, 1'b1, "R1 R2 open addr");
        setup(1'b0, 1'b0, 8'h3C, 8'hFF);
        send(8'h12, 1'b0, "R1 R2 open bad stop");
        @(negedge clk);
        check("R2 disabled match", match_out, 1'b1);

        setup(1'b1, 1'b1, 8'h3C, 8'hFF);
        send(8'h55, 1'b0, "R6 data after reenable");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard left=%0d expected=0", q.size());
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule